// File: doc/BRIEF.md
# Security-Banked Peripheral Window Router

This block sits between a small processor's load/store path and the private peripheral window, a 1 MB span of addresses starting at 0xE0000000. Each request carries an address, write data, a byte count, a write flag and two attributes: secure and unprivileged. The router picks one target port for the request, or none. The targets are a system-register port, which serves the interrupt controller and the control space, two timer register ports (a secure bank and a non-secure bank), and an optional reliability-register port. The router sends the access on with an offset that is relative to the region base.

Regions overlap, and a fixed priority settles the overlap. The timer and reliability blocks rank highest, the system-register region comes next, and an internal default responder ranks lowest. An optional alias of the system-register and timer regions sits 0x20000 above the real regions. A secure access to the alias is re-issued as a non-secure access to the real target. A non-secure access to the alias gets the default behaviour. Unclaimed addresses behave like this: a privileged access reads zero and its write is dropped, and an unprivileged access gets a bus error. A request is accepted in one cycle, and its response (error flag and read data) appears on the next cycle.

Top module: `ppb_route`

## Requirements
- R1: An address in 0xE0000000–0xE00FFFFF that no enabled region claims selects no target. Privileged, it responds with error 0 and read data 0. Unprivileged, it responds with error 1 and read data 0.
- R2: Addresses 0xE000E000–0xE000EFFF that are not taken by a higher-priority region select the system-register port. The offset is address minus 0xE000E000, and the secure attribute passes through unchanged.
- R3: Addresses 0xE000E010–0xE000E0EF select a timer port rather than the system-register port, with offset equal to address minus 0xE000E010. Addresses 0xE000E00F and 0xE000E0F0 stay with the system-register port.
- R4: A timer access with the secure attribute set selects the secure timer port, and one without it selects the non-secure timer port. When the security option is off, the secure port is never selected.
- R5: With the alias option on, a secure access to 0xE002E000–0xE002EFFF that does not fall in the timer alias goes to the system-register port. It carries the same offset as the real region, and the forwarded secure attribute is 0.
- R6: A non-secure access to either alias window selects no target. Privileged, it responds with error 0 and data 0. Unprivileged, it responds with error 1. A write made this way leaves the target's contents unchanged.
- R7: A secure access to 0xE002E010–0xE002E0EF selects the non-secure timer port, with offset relative to 0xE002E010 and forwarded secure attribute 0.
- R8: With the reliability option on, addresses 0xE0005000–0xE0005FFF select the reliability port, with offset relative to 0xE0005000.
- R9: A byte count of 1 to 8 is legal. A count of 0 or above 8 selects no target and responds with error 1.
- R10: An address outside the 1 MB window selects no target and responds with error 1.
- R11: The response to a routed access returns the selected target's read data and error flag unchanged.
- R12: req_ready is 0 during reset and 1 from the first clock edge after reset. rsp_valid is 1 exactly in the cycle after an accepted request. A target select is high only while a request is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Write data |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Bus error |
| rsp_rdata | output | 64 | Read data |
| sel_sys | output | 1 | System-register port select |
| sel_tmr_s | output | 1 | Secure timer port select |
| sel_tmr_ns | output | 1 | Non-secure timer port select |
| sel_rel | output | 1 | Reliability port select |
| tgt_offset | output | 12 | Offset inside the selected region |
| tgt_wdata | output | 64 | Write data to target |
| tgt_size | output | 4 | Size to target |
| tgt_write | output | 1 | Write flag to target |
| tgt_secure | output | 1 | Forwarded secure attribute |
| tgt_user | output | 1 | Forwarded unprivileged attribute |
| sys_rdata | input | 64 | System-register read data |
| sys_err | input | 1 | System-register error |
| tmr_s_rdata | input | 64 | Secure timer read data |
| tmr_s_err | input | 1 | Secure timer error |
| tmr_ns_rdata | input | 64 | Non-secure timer read data |
| tmr_ns_err | input | 1 | Non-secure timer error |
| rel_rdata | input | 64 | Reliability read data |
| rel_err | input | 1 | Reliability error |

## Verification
The bench builds the router with the alias, security and reliability options all on. With that build, every region and both timer banks can be reached: the timer aliases' re-issue as non-secure, the secure-bank steering and the reliability block. The option-off paths are not reached by this build, such as the alias window falling through to the default responder. Stub register files stand in for the targets. One system-register offset band in the stubs raises an error, so that error propagation can be observed. Writes made through the main region and through the alias are read back through the other path.

// File: rtl/ppb_route_pkg.sv
package ppb_route_pkg;

  typedef enum logic [2:0] {
    ACT_RAZ    = 3'd0,
    ACT_FAULT  = 3'd1,
    ACT_SYS    = 3'd2,
    ACT_TMR_S  = 3'd3,
    ACT_TMR_NS = 3'd4,
    ACT_REL    = 3'd5
  } act_e;

  // Region indices, listed from highest to lowest priority
  localparam int RG_TMR    = 0;
  localparam int RG_TMR_AL = 1;
  localparam int RG_REL    = 2;
  localparam int RG_SYS    = 3;
  localparam int RG_SYS_AL = 4;
  localparam int NUM_RG    = 5;

  localparam logic [31:0] WIN_BASE   = 32'hE000_0000;
  localparam logic [31:0] ALIAS_STEP = 32'h0002_0000;
  localparam logic [31:0] SYS_BASE   = 32'hE000_E000;
  localparam logic [31:0] SYS_SPAN   = 32'h0000_1000;
  localparam logic [31:0] TMR_BASE   = 32'hE000_E010;
  localparam logic [31:0] TMR_SPAN   = 32'h0000_00E0;
  localparam logic [31:0] REL_BASE   = 32'hE000_5000;
  localparam logic [31:0] REL_SPAN   = 32'h0000_1000;

  function automatic logic [31:0] rg_base(input int idx);
    case (idx)
      RG_TMR:    return TMR_BASE;
      RG_TMR_AL: return TMR_BASE + ALIAS_STEP;
      RG_REL:    return REL_BASE;
      RG_SYS:    return SYS_BASE;
      default:   return SYS_BASE + ALIAS_STEP;
    endcase
  endfunction

  function automatic logic [31:0] rg_span(input int idx);
    case (idx)
      RG_TMR, RG_TMR_AL: return TMR_SPAN;
      RG_REL:            return REL_SPAN;
      default:           return SYS_SPAN;
    endcase
  endfunction

  function automatic bit rg_on(input int idx, input bit alias_on, input bit rel_on);
    case (idx)
      RG_TMR_AL, RG_SYS_AL: return alias_on;
      RG_REL:               return rel_on;
      default:              return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ppb_region_match.sv
module ppb_region_match #(
  parameter logic [31:0] BASE   = 32'h0,
  parameter logic [31:0] SPAN   = 32'h1000,
  parameter int          OFFW   = 12,
  parameter bit          ENABLE = 1'b1
) (
  input  logic [31:0]     addr,
  output logic            hit,
  output logic [OFFW-1:0] offset
);

  logic [32:0] diff;

  always_comb begin
    diff   = {1'b0, addr} - {1'b0, BASE};
    hit    = ENABLE && !diff[32] && (diff[31:0] < SPAN);
    offset = diff[OFFW-1:0];
  end

endmodule

// File: rtl/ppb_route_decide.sv
module ppb_route_decide
  import ppb_route_pkg::*;
#(
  parameter int OFFW    = 12,
  parameter int SZW     = 4,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic [NUM_RG-1:0]           hit,
  input  logic [NUM_RG-1:0][OFFW-1:0] offs,
  input  logic                        in_window,
  input  logic [SZW-1:0]              size,
  input  logic                        secure,
  input  logic                        user,
  output act_e                        act,
  output logic [OFFW-1:0]             offset,
  output logic                        fwd_secure
);

  localparam logic [SZW-1:0] MAX_BYTES = SZW'(8);

  logic sec_eff;
  logic size_ok;
  act_e idle_act;

  always_comb begin
    sec_eff  = secure & HAS_SEC;
    size_ok  = (size != '0) && (size <= MAX_BYTES);
    idle_act = user ? ACT_FAULT : ACT_RAZ;

    act        = idle_act;
    offset     = '0;
    fwd_secure = sec_eff;

    if (!in_window || !size_ok) begin
      act = ACT_FAULT;
    end else if (hit[RG_TMR]) begin
      act    = sec_eff ? ACT_TMR_S : ACT_TMR_NS;
      offset = offs[RG_TMR];
    end else if (hit[RG_TMR_AL]) begin
      act        = sec_eff ? ACT_TMR_NS : idle_act;
      offset     = offs[RG_TMR_AL];
      fwd_secure = 1'b0;
    end else if (hit[RG_REL]) begin
      act    = ACT_REL;
      offset = offs[RG_REL];
    end else if (hit[RG_SYS]) begin
      act    = ACT_SYS;
      offset = offs[RG_SYS];
    end else if (hit[RG_SYS_AL]) begin
      act        = sec_eff ? ACT_SYS : idle_act;
      offset     = offs[RG_SYS_AL];
      fwd_secure = 1'b0;
    end
  end

endmodule

// File: rtl/ppb_rsp_stage.sv
module ppb_rsp_stage
  import ppb_route_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  act_e          act,
  input  logic [DW-1:0] sys_rdata,
  input  logic          sys_err,
  input  logic [DW-1:0] tmr_s_rdata,
  input  logic          tmr_s_err,
  input  logic [DW-1:0] tmr_ns_rdata,
  input  logic          tmr_ns_err,
  input  logic [DW-1:0] rel_rdata,
  input  logic          rel_err,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);

  logic          valid_d;
  logic          err_d;
  logic [DW-1:0] data_d;
  logic          load_en;

  always_comb begin
    valid_d = accept;
    load_en = accept;
    err_d   = 1'b0;
    data_d  = '0;
    case (act)
      ACT_FAULT:  err_d = 1'b1;
      ACT_SYS:    begin err_d = sys_err;    data_d = sys_rdata;    end
      ACT_TMR_S:  begin err_d = tmr_s_err;  data_d = tmr_s_rdata;  end
      ACT_TMR_NS: begin err_d = tmr_ns_err; data_d = tmr_ns_rdata; end
      ACT_REL:    begin err_d = rel_err;    data_d = rel_rdata;    end
      default:    err_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (load_en) begin
      rsp_err   <= err_d;
      rsp_rdata <= data_d;
    end
  end

endmodule

// File: rtl/ppb_route.sv
module ppb_route
  import ppb_route_pkg::*;
#(
  parameter int DW        = 64,
  parameter int OFFW      = 12,
  parameter int SZW       = 4,
  parameter bit HAS_ALIAS = 1'b1,
  parameter bit HAS_SEC   = 1'b1,
  parameter bit HAS_REL   = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [SZW-1:0]  req_size,
  input  logic            req_write,
  input  logic            req_secure,
  input  logic            req_user,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_rdata,
  output logic            sel_sys,
  output logic            sel_tmr_s,
  output logic            sel_tmr_ns,
  output logic            sel_rel,
  output logic [OFFW-1:0] tgt_offset,
  output logic [DW-1:0]   tgt_wdata,
  output logic [SZW-1:0]  tgt_size,
  output logic            tgt_write,
  output logic            tgt_secure,
  output logic            tgt_user,
  input  logic [DW-1:0]   sys_rdata,
  input  logic            sys_err,
  input  logic [DW-1:0]   tmr_s_rdata,
  input  logic            tmr_s_err,
  input  logic [DW-1:0]   tmr_ns_rdata,
  input  logic            tmr_ns_err,
  input  logic [DW-1:0]   rel_rdata,
  input  logic            rel_err
);

  localparam logic [11:0] WIN_TAG = WIN_BASE[31:20];

  logic [NUM_RG-1:0]           hit;
  logic [NUM_RG-1:0][OFFW-1:0] offs;
  logic                        in_window;
  logic                        accept;
  logic                        ready_d;
  act_e                        act;
  logic [OFFW-1:0]             dec_offset;
  logic                        dec_secure;

  // Ready: low in reset, high from the first edge after release
  always_comb ready_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
    end else begin
      req_ready <= ready_d;
    end
  end

  assign accept    = req_valid & req_ready;
  assign in_window = (req_addr[31:20] == WIN_TAG);

  for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
    ppb_region_match #(
      .BASE   (rg_base(g)),
      .SPAN   (rg_span(g)),
      .OFFW   (OFFW),
      .ENABLE (rg_on(g, HAS_ALIAS, HAS_REL))
    ) i_match (
      .addr   (req_addr),
      .hit    (hit[g]),
      .offset (offs[g])
    );
  end

  ppb_route_decide #(
    .OFFW    (OFFW),
    .SZW     (SZW),
    .HAS_SEC (HAS_SEC)
  ) i_decide (
    .hit        (hit),
    .offs       (offs),
    .in_window  (in_window),
    .size       (req_size),
    .secure     (req_secure),
    .user       (req_user),
    .act        (act),
    .offset     (dec_offset),
    .fwd_secure (dec_secure)
  );

  always_comb begin
    sel_sys    = accept && (act == ACT_SYS);
    sel_tmr_s  = accept && (act == ACT_TMR_S);
    sel_tmr_ns = accept && (act == ACT_TMR_NS);
    sel_rel    = accept && (act == ACT_REL);
    tgt_offset = dec_offset;
    tgt_wdata  = req_wdata;
    tgt_size   = req_size;
    tgt_write  = req_write;
    tgt_secure = dec_secure;
    tgt_user   = req_user;
  end

  ppb_rsp_stage #(
    .DW (DW)
  ) i_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .act          (act),
    .sys_rdata    (sys_rdata),
    .sys_err      (sys_err),
    .tmr_s_rdata  (tmr_s_rdata),
    .tmr_s_err    (tmr_s_err),
    .tmr_ns_rdata (tmr_ns_rdata),
    .tmr_ns_err   (tmr_ns_err),
    .rel_rdata    (rel_rdata),
    .rel_err      (rel_err),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata)
  );

endmodule

// File: rtl/ppb_route_chk.sv
module ppb_route_chk #(
  parameter int DW  = 64,
  parameter int SZW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [31:0]    req_addr,
  input logic [SZW-1:0] req_size,
  input logic           req_secure,
  input logic           req_user,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [DW-1:0]  rsp_rdata,
  input logic           sel_sys,
  input logic           sel_tmr_s,
  input logic           sel_tmr_ns,
  input logic           sel_rel,
  input logic           tgt_secure,
  input logic           sys_err
);

  logic acc;
  logic any_sel;
  assign acc     = req_valid && req_ready;
  assign any_sel = sel_sys | sel_tmr_s | sel_tmr_ns | sel_rel;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sys, sel_tmr_s, sel_tmr_ns, sel_rel})); // R3

  AST_SEL_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> acc); // R12

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R12

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R12

  AST_USER_UNCLAIMED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !any_sel && req_user) |=> rsp_err); // R1

  AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !any_sel) |=> (rsp_rdata == '0)); // R1

  AST_SECURE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tmr_s |-> req_secure); // R4

  AST_ALIAS_CLEARS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel && (req_addr[31:12] == 20'hE002E)) |-> !tgt_secure); // R5

  AST_ALIAS_NS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_secure && (req_addr[31:12] == 20'hE002E)) |-> !any_sel); // R6

  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ((req_size == '0) || (req_size > SZW'(8)))) |=> rsp_err); // R9

  AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_addr[31:20] != 12'hE00)) |=> rsp_err); // R10

  AST_ERR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sys && sys_err) |=> rsp_err); // R11

endmodule

bind ppb_route ppb_route_chk #(.DW(DW), .SZW(SZW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .req_secure (req_secure),
  .req_user   (req_user),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .sel_sys    (sel_sys),
  .sel_tmr_s  (sel_tmr_s),
  .sel_tmr_ns (sel_tmr_ns),
  .sel_rel    (sel_rel),
  .tgt_secure (tgt_secure),
  .sys_err    (sys_err)
);

// File: tb/test_ppb_route.sv
`timescale 1ns/1ps
module test_ppb_route;

  localparam int K_Z = 0, K_F = 1, K_SYS = 2, K_TS = 3, K_TN = 4, K_REL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [3:0]  req_size = 4'd4;
  logic        req_write = 1'b0;
  logic        req_secure = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        sel_sys, sel_tmr_s, sel_tmr_ns, sel_rel;
  logic [11:0] tgt_offset;
  logic [63:0] tgt_wdata;
  logic [3:0]  tgt_size;
  logic        tgt_write, tgt_secure, tgt_user;
  logic [63:0] sys_rdata, tmr_s_rdata, tmr_ns_rdata, rel_rdata;
  logic        sys_err, tmr_s_err, tmr_ns_err, rel_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ppb_route #(.HAS_ALIAS(1'b1), .HAS_SEC(1'b1), .HAS_REL(1'b1)) i_ppb_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_write(req_write), .req_secure(req_secure), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .sel_sys(sel_sys), .sel_tmr_s(sel_tmr_s), .sel_tmr_ns(sel_tmr_ns), .sel_rel(sel_rel),
    .tgt_offset(tgt_offset), .tgt_wdata(tgt_wdata), .tgt_size(tgt_size),
    .tgt_write(tgt_write), .tgt_secure(tgt_secure), .tgt_user(tgt_user),
    .sys_rdata(sys_rdata), .sys_err(sys_err), .tmr_s_rdata(tmr_s_rdata),
    .tmr_s_err(tmr_s_err), .tmr_ns_rdata(tmr_ns_rdata), .tmr_ns_err(tmr_ns_err),
    .rel_rdata(rel_rdata), .rel_err(rel_err)
  );

  // Target stubs: plain register files, an error band at offsets 0xFF0..0xFFF
  bit [63:0] stub [4][512];
  logic stub_err;
  assign stub_err     = (tgt_offset[11:4] == 8'hFF);
  assign sys_rdata    = stub[0][tgt_offset[11:3]];
  assign tmr_s_rdata  = stub[1][tgt_offset[11:3]];
  assign tmr_ns_rdata = stub[2][tgt_offset[11:3]];
  assign rel_rdata    = stub[3][tgt_offset[11:3]];
  assign sys_err = stub_err;
  assign tmr_s_err = stub_err;
  assign tmr_ns_err = stub_err;
  assign rel_err = stub_err;

  always @(posedge clk) begin
    if (tgt_write && !stub_err) begin
      if (sel_sys)    stub[0][tgt_offset[11:3]] <= tgt_wdata;
      if (sel_tmr_s)  stub[1][tgt_offset[11:3]] <= tgt_wdata;
      if (sel_tmr_ns) stub[2][tgt_offset[11:3]] <= tgt_wdata;
      if (sel_rel)    stub[3][tgt_offset[11:3]] <= tgt_wdata;
    end
  end

  // Behavioural reference of the decode rules
  function automatic void predict(input logic [31:0] a, input int sz, input bit sec,
                                  input bit usr, output int k, output int off,
                                  output bit fsec);
    longint unsigned ua = a;
    int idle = usr ? K_F : K_Z;
    k = idle; off = 0; fsec = sec;
    if (ua < 64'hE000_0000 || ua > 64'hE00F_FFFF || sz < 1 || sz > 8) k = K_F;
    else if (ua >= 64'hE000_E010 && ua < 64'hE000_E0F0) begin
      k = sec ? K_TS : K_TN; off = int'(ua - 64'hE000_E010);
    end else if (ua >= 64'hE002_E010 && ua < 64'hE002_E0F0) begin
      k = sec ? K_TN : idle; off = int'(ua - 64'hE002_E010); fsec = 0;
    end else if (ua >= 64'hE000_5000 && ua < 64'hE000_6000) begin
      k = K_REL; off = int'(ua - 64'hE000_5000);
    end else if (ua >= 64'hE000_E000 && ua < 64'hE000_F000) begin
      k = K_SYS; off = int'(ua - 64'hE000_E000);
    end else if (ua >= 64'hE002_E000 && ua < 64'hE002_F000) begin
      k = sec ? K_SYS : idle; off = int'(ua - 64'hE002_E000); fsec = 0;
    end
  endfunction

  bit [63:0] shadow [4][512];
  string     cur_tag = "R12";
  bit        exp_v = 0, exp_e = 0;
  logic [63:0] exp_d = '0;
  string     exp_tag = "R12";

  // Prediction and shadow update at each edge (inputs are stable here)
  always @(posedge clk) begin
    int k, off; bit fs; bit te; bit e; logic [63:0] d;
    if (rst_n) begin
      predict(req_addr, int'(req_size), req_secure, req_user, k, off, fs);
      e = 0; d = '0;
      if (k == K_F) e = 1;
      else if (k >= K_SYS) begin
        te = ((off >> 4) == 255);
        e = te;
        d = shadow[k-2][off >> 3];
        if (req_valid && req_write && !te) shadow[k-2][off >> 3] = req_wdata;
      end
      exp_v   <= req_valid;
      exp_e   <= e;
      exp_d   <= d;
      exp_tag <= cur_tag;
    end
  end

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Response comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(exp_tag, rsp_valid == exp_v, "rsp_valid", 64'(rsp_valid), 64'(exp_v));
      if (exp_v) begin
        check(exp_tag, rsp_err == exp_e, "rsp_err", 64'(rsp_err), 64'(exp_e));
        check(exp_tag, rsp_rdata == exp_d, "rsp_rdata", rsp_rdata, exp_d);
      end
    end
  end

  task automatic access(input logic [31:0] a, input int sz, input bit wr,
                        input logic [63:0] wd, input bit sec, input bit usr,
                        input string tag);
    int k, off; bit fs;
    logic [3:0] esel;
    @(negedge clk);
    cur_tag = tag;
    req_addr = a; req_size = 4'(sz); req_write = wr; req_wdata = wd;
    req_secure = sec; req_user = usr; req_valid = 1'b1;
    #1;
    predict(a, sz, sec, usr, k, off, fs);
    esel = 4'b0000;
    if (k >= K_SYS) esel[k-2] = 1'b1;
    check(tag, {sel_rel, sel_tmr_ns, sel_tmr_s, sel_sys} == esel, "selects",
          64'({sel_rel, sel_tmr_ns, sel_tmr_s, sel_sys}), 64'(esel));
    if (k >= K_SYS) begin
      check(tag, tgt_offset == 12'(off), "tgt_offset", 64'(tgt_offset), 64'(off));
      check(tag, tgt_secure == fs, "tgt_secure", 64'(tgt_secure), 64'(fs));
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", req_ready == 1'b0, "ready in reset", 64'(req_ready), 64'd0);
    check("R12", rsp_valid == 1'b0, "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", req_ready == 1'b1, "ready after reset", 64'(req_ready), 64'd1);

    // R1 unclaimed space
    access(32'hE000_1000, 4, 0, '0, 0, 0, "R1");
    access(32'hE000_1000, 4, 0, '0, 0, 1, "R1");
    access(32'hE00F_FFF8, 8, 1, 64'h55, 1, 1, "R1");
    // R2 system registers, write then read, both attributes
    access(32'hE000_ED08, 4, 1, 64'h1234_5678_9ABC_DEF0, 1, 0, "R2");
    access(32'hE000_ED08, 4, 0, '0, 0, 0, "R2");
    access(32'hE000_E004, 4, 0, '0, 1, 1, "R2");
    // R3 / R4 timer priority and banking
    access(32'hE000_E018, 4, 1, 64'hA5A5, 1, 0, "R4");
    access(32'hE000_E018, 4, 1, 64'h5A5A, 0, 0, "R4");
    access(32'hE000_E018, 4, 0, '0, 1, 0, "R4");
    access(32'hE000_E018, 4, 0, '0, 0, 0, "R4");
    access(32'hE000_E010, 4, 0, '0, 0, 0, "R3");
    access(32'hE000_E0EF, 1, 0, '0, 1, 0, "R3");
    access(32'hE000_E00F, 1, 0, '0, 0, 0, "R3");
    access(32'hE000_E0F0, 4, 0, '0, 0, 0, "R3");
    // R5 secure alias of system registers
    access(32'hE002_ED08, 4, 0, '0, 1, 0, "R5");
    access(32'hE002_ED10, 4, 1, 64'hCAFE, 1, 0, "R5");
    access(32'hE000_ED10, 4, 0, '0, 0, 0, "R5");
    // R6 non-secure alias: ignored writes, errors for unprivileged
    access(32'hE002_ED10, 4, 1, 64'hDEAD, 0, 0, "R6");
    access(32'hE000_ED10, 4, 0, '0, 0, 0, "R6");
    access(32'hE002_ED10, 4, 0, '0, 0, 1, "R6");
    access(32'hE002_E018, 4, 0, '0, 0, 0, "R6");
    // R7 timer alias
    access(32'hE002_E018, 4, 0, '0, 1, 0, "R7");
    access(32'hE002_E020, 4, 1, 64'h77, 1, 1, "R7");
    access(32'hE000_E020, 4, 0, '0, 0, 0, "R7");
    // R8 reliability block
    access(32'hE000_5010, 8, 1, 64'h0123_4567, 0, 0, "R8");
    access(32'hE000_5010, 8, 0, '0, 1, 0, "R8");
    access(32'hE000_4FF8, 8, 0, '0, 0, 0, "R8");
    // R9 size limits
    access(32'hE000_ED08, 0, 0, '0, 0, 0, "R9");
    access(32'hE000_ED08, 9, 0, '0, 0, 0, "R9");
    access(32'hE000_ED08, 8, 0, '0, 0, 0, "R9");
    access(32'hE000_1000, 1, 0, '0, 0, 0, "R9");
    // R10 outside window
    access(32'hE010_0000, 4, 0, '0, 1, 0, "R10");
    access(32'hDFFF_FFFC, 4, 0, '0, 0, 0, "R10");
    // R11 target error passes through
    access(32'hE000_EFF0, 4, 0, '0, 0, 0, "R11");
    access(32'hE002_EFF8, 4, 1, 64'h9, 1, 0, "R11");
    // R12 idle cycles produce no response
    repeat (3) @(negedge clk);
    cur_tag = "R12";
    access(32'hE000_ED00, 4, 0, '0, 0, 0, "R12");
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule